// File: doc/BRIEF.md
# Timer Interrupt Status Flag Unit

This unit keeps the sticky event and status flags of a small timer and drives the timer's single interrupt line. The timer core sends it one-cycle pulses: a compare match for each channel, an auto-reload match, an external trigger edge, encoder direction reversals, update events, and write-complete pulses for the compare, auto-reload, repetition and interrupt-enable registers. Each pulse sets its flag, and the flag stays set until software clears it.

Software reads the 16-bit flag word over a simple bus. It clears flags by writing ones to a separate clear port, where zeros are ignored. It chooses which flags reach the interrupt line through an enable register of the same layout. The interrupt output is level-sensitive. It is high while any enabled flag is set.

A parameter sets how many compare channels exist, from 1 to 4. Flags that belong to channels that are not built read as zero. Their enable bits also read as zero.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, the flag word reads 0x0000, the enable word reads 0x0000 and `irq` is low.
- R2: A pulse on `ev_cmp_match[k]` sets flag bit 5+k only while `ch_is_out[k]` is 1. It has no effect while `ch_is_out[k]` is 0.
- R3: A pulse on `ev_arr_match` sets flag bit 0.
- R4: A pulse on `ev_trig_edge` sets flag bit 1 only when `tmr_running` is 0. The pulse is ignored while the timer is running.
- R5: While `enc_mode` is 1, `ev_dir_up` sets bit 3 (down-to-up reversal) and `ev_dir_down` sets bit 4 (up-to-down reversal). Outside encoder mode, both pulses are ignored.
- R6: `ev_update` sets bit 2. A pulse on `arr_write` clears bit 2 in hardware.
- R7: The write-complete pulses set the following bits: `wdone_cmp[k]` sets bit 9+k, `wdone_arr` sets bit 13, `wdone_rep` sets bit 14 and `wdone_ien` sets bit 15.
- R8: A cycle with `clr_we` high clears each flag whose bit in `clr_wdata` is 1. Bits written as 0 leave their flags unchanged.
- R9: If a set pulse meets a clear of the same flag in the same cycle, the flag ends up set. The clear may come from software or from `arr_write`.
- R10: For each channel k at or above `NCH`, flag bits 5+k and 9+k and the matching enable bits always read 0.
- R11: `ien_we` loads the enable word. `irq` is high exactly when some flag bit and its enable bit are both 1, and it stays high until those flags are cleared.
- R12: Flags change only through a set pulse, a software clear or `arr_write`. Without any of these, the flag word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_cmp_match | input | 4 | Per-channel compare match pulse |
| ch_is_out | input | 4 | Per-channel output-mode configuration |
| ev_arr_match | input | 1 | Counter reached auto-reload value |
| ev_trig_edge | input | 1 | Valid edge on selected trigger input |
| tmr_running | input | 1 | Timer already started |
| enc_mode | input | 1 | Encoder mode active |
| ev_dir_up | input | 1 | Direction changed down to up |
| ev_dir_down | input | 1 | Direction changed up to down |
| ev_update | input | 1 | Update event generated |
| wdone_cmp | input | 4 | Compare register write completed, per channel |
| wdone_arr | input | 1 | Auto-reload register write completed |
| wdone_rep | input | 1 | Repetition register write completed |
| wdone_ien | input | 1 | Interrupt-enable register write completed |
| arr_write | input | 1 | Any bus master writes the auto-reload register |
| clr_we | input | 1 | Clear-register write strobe |
| clr_wdata | input | 16 | Write-1-to-clear data |
| ien_we | input | 1 | Enable-register write strobe |
| ien_wdata | input | 16 | Enable-register write data |
| rd_flags | output | 16 | Flag word read data |
| rd_ien | output | 16 | Enable word read data |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that every event input is a clean synchronous pulse, already moved into this clock domain, and that the inputs are steady around each rising edge. They also assume that the clear and enable strobes last exactly one cycle per bus write.

The bench drives all inputs on the falling edge and holds them for one full cycle before it returns them to idle. It starts most scenarios by clearing every flag, so that each check compares the whole flag word against a known value. A second instance with two channels shares the same stimulus, and it is used to check the bits that are not built.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int MAXCH = 4;
    localparam int FW    = 16;

    localparam int F_ARRM  = 0;
    localparam int F_TRIG  = 1;
    localparam int F_UPD   = 2;
    localparam int F_DUP   = 3;
    localparam int F_DDN   = 4;
    localparam int F_CMP0  = 5;
    localparam int F_CWOK0 = 9;
    localparam int F_AWOK  = 13;
    localparam int F_RWOK  = 14;
    localparam int F_IWOK  = 15;

    typedef logic [FW-1:0] flag_vec_t;

    function automatic flag_vec_t impl_mask(input int nch);
        flag_vec_t m;
        m = '1;
        for (int k = 0; k < MAXCH; k++) begin
            if (k >= nch) begin
                m[F_CMP0 + k]  = 1'b0;
                m[F_CWOK0 + k] = 1'b0;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_irq_event_map.sv
module tmr_irq_event_map
    import tmr_irq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [MAXCH-1:0] ev_cmp_match,
    input  logic [MAXCH-1:0] ch_is_out,
    input  logic             ev_arr_match,
    input  logic             ev_trig_edge,
    input  logic             tmr_running,
    input  logic             enc_mode,
    input  logic             ev_dir_up,
    input  logic             ev_dir_down,
    input  logic             ev_update,
    input  logic [MAXCH-1:0] wdone_cmp,
    input  logic             wdone_arr,
    input  logic             wdone_rep,
    input  logic             wdone_ien,
    output flag_vec_t        set_vec
);

    logic [MAXCH-1:0] cmp_set;
    logic [MAXCH-1:0] cwok_set;

    for (genvar k = 0; k < MAXCH; k++) begin : g_ch
        if (k < NCH) begin : g_live
            assign cmp_set[k]  = ev_cmp_match[k] & ch_is_out[k];
            assign cwok_set[k] = wdone_cmp[k];
        end else begin : g_absent
            assign cmp_set[k]  = 1'b0;
            assign cwok_set[k] = 1'b0;
        end
    end

    always_comb begin
        set_vec         = '0;
        set_vec[F_ARRM] = ev_arr_match;
        set_vec[F_TRIG] = ev_trig_edge & ~tmr_running;
        set_vec[F_UPD]  = ev_update;
        set_vec[F_DUP]  = ev_dir_up & enc_mode;
        set_vec[F_DDN]  = ev_dir_down & enc_mode;
        set_vec[F_CMP0 +: MAXCH]  = cmp_set;
        set_vec[F_CWOK0 +: MAXCH] = cwok_set;
        set_vec[F_AWOK] = wdone_arr;
        set_vec[F_RWOK] = wdone_rep;
        set_vec[F_IWOK] = wdone_ien;
    end

endmodule

// File: rtl/tmr_irq_flag_reg.sv
module tmr_irq_flag_reg
    import tmr_irq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_vec,
    input  logic      clr_we,
    input  flag_vec_t clr_wdata,
    input  logic      arr_write,
    output flag_vec_t flags_q
);

    localparam flag_vec_t IMPL = impl_mask(NCH);

    typedef struct packed {
        flag_vec_t flags;
    } fstate_t;

    fstate_t   st_d, st_q;
    flag_vec_t clr_mask;

    always_comb begin
        clr_mask = clr_we ? clr_wdata : '0;
        if (arr_write) clr_mask[F_UPD] = 1'b1;
        st_d.flags = ((st_q.flags & ~clr_mask) | set_vec) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)))
        else $error("set pulse lost");

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((flags_q & $past(clr_wdata & ~set_vec)) == '0))
        else $error("write-1 clear ignored");

    assert_upd_hwclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_write && !set_vec[F_UPD]) |=> !flags_q[F_UPD])
        else $error("update flag not cleared by reload write");

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && !arr_write && set_vec == '0) |=> $stable(flags_q))
        else $error("flags changed without cause");

endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate
    import tmr_irq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ien_we,
    input  flag_vec_t ien_wdata,
    input  flag_vec_t flags_q,
    output flag_vec_t ien_q,
    output logic      irq
);

    localparam flag_vec_t IMPL = impl_mask(NCH);

    typedef struct packed {
        flag_vec_t ien;
    } gstate_t;

    gstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ien_we) st_d.ien = ien_wdata & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien_q = st_q.ien;
    assign irq   = |(flags_q & st_q.ien);

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags_q != '0 && ien_q != '0))
        else $error("irq without enabled flag");

    assert_ien_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ien_we |=> (ien_q == $past(ien_wdata & IMPL)))
        else $error("enable word not loaded");

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  ev_cmp_match,
    input  logic [3:0]  ch_is_out,
    input  logic        ev_arr_match,
    input  logic        ev_trig_edge,
    input  logic        tmr_running,
    input  logic        enc_mode,
    input  logic        ev_dir_up,
    input  logic        ev_dir_down,
    input  logic        ev_update,
    input  logic [3:0]  wdone_cmp,
    input  logic        wdone_arr,
    input  logic        wdone_rep,
    input  logic        wdone_ien,
    input  logic        arr_write,
    input  logic        clr_we,
    input  logic [15:0] clr_wdata,
    input  logic        ien_we,
    input  logic [15:0] ien_wdata,
    output logic [15:0] rd_flags,
    output logic [15:0] rd_ien,
    output logic        irq
);

    localparam flag_vec_t IMPL = impl_mask(NCH);

    flag_vec_t set_vec;
    flag_vec_t flags_q;
    flag_vec_t ien_q;

    tmr_irq_event_map #(.NCH(NCH)) u_map (
        .ev_cmp_match (ev_cmp_match),
        .ch_is_out    (ch_is_out),
        .ev_arr_match (ev_arr_match),
        .ev_trig_edge (ev_trig_edge),
        .tmr_running  (tmr_running),
        .enc_mode     (enc_mode),
        .ev_dir_up    (ev_dir_up),
        .ev_dir_down  (ev_dir_down),
        .ev_update    (ev_update),
        .wdone_cmp    (wdone_cmp),
        .wdone_arr    (wdone_arr),
        .wdone_rep    (wdone_rep),
        .wdone_ien    (wdone_ien),
        .set_vec      (set_vec)
    );

    tmr_irq_flag_reg #(.NCH(NCH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .arr_write (arr_write),
        .flags_q   (flags_q)
    );

    tmr_irq_gate #(.NCH(NCH)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_we    (ien_we),
        .ien_wdata (ien_wdata),
        .flags_q   (flags_q),
        .ien_q     (ien_q),
        .irq       (irq)
    );

    assign rd_flags = flags_q;
    assign rd_ien   = ien_q;

    assert_trig_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_trig_edge && tmr_running && !rd_flags[F_TRIG]) |=> !rd_flags[F_TRIG])
        else $error("trigger flagged while running");

    assert_cmp_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_flags[F_CMP0 +: 4] == '0) && !(|(ev_cmp_match & ch_is_out))) |=> (rd_flags[F_CMP0 +: 4] == '0))
        else $error("compare flag set without output-mode match");

    assert_absent_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_flags & ~IMPL) == '0) && ((rd_ien & ~IMPL) == '0))
        else $error("unbuilt channel bit set");

endmodule

// File: tb/tb_tmr_irq_flags.sv
module tb_tmr_irq_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ev_cmp_match, ch_is_out, wdone_cmp;
    logic        ev_arr_match, ev_trig_edge, tmr_running, enc_mode;
    logic        ev_dir_up, ev_dir_down, ev_update;
    logic        wdone_arr, wdone_rep, wdone_ien, arr_write;
    logic        clr_we, ien_we;
    logic [15:0] clr_wdata, ien_wdata;
    logic [15:0] rd_flags, rd_ien, rd_flags2, rd_ien2;
    logic        irq, irq2;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tmr_irq_flags #(.NCH(4)) dut (
        .clk(clk), .rst_n(rst_n), .ev_cmp_match(ev_cmp_match), .ch_is_out(ch_is_out),
        .ev_arr_match(ev_arr_match), .ev_trig_edge(ev_trig_edge), .tmr_running(tmr_running),
        .enc_mode(enc_mode), .ev_dir_up(ev_dir_up), .ev_dir_down(ev_dir_down),
        .ev_update(ev_update), .wdone_cmp(wdone_cmp), .wdone_arr(wdone_arr),
        .wdone_rep(wdone_rep), .wdone_ien(wdone_ien), .arr_write(arr_write),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .rd_flags(rd_flags), .rd_ien(rd_ien), .irq(irq)
    );

    tmr_irq_flags #(.NCH(2)) dut_n2 (
        .clk(clk), .rst_n(rst_n), .ev_cmp_match(ev_cmp_match), .ch_is_out(ch_is_out),
        .ev_arr_match(ev_arr_match), .ev_trig_edge(ev_trig_edge), .tmr_running(tmr_running),
        .enc_mode(enc_mode), .ev_dir_up(ev_dir_up), .ev_dir_down(ev_dir_down),
        .ev_update(ev_update), .wdone_cmp(wdone_cmp), .wdone_arr(wdone_arr),
        .wdone_rep(wdone_rep), .wdone_ien(wdone_ien), .arr_write(arr_write),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .rd_flags(rd_flags2), .rd_ien(rd_ien2), .irq(irq2)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        ev_cmp_match = '0; ch_is_out = '0; wdone_cmp = '0;
        ev_arr_match = 0; ev_trig_edge = 0; tmr_running = 0; enc_mode = 0;
        ev_dir_up = 0; ev_dir_down = 0; ev_update = 0;
        wdone_arr = 0; wdone_rep = 0; wdone_ien = 0; arr_write = 0;
        clr_we = 0; ien_we = 0; clr_wdata = '0; ien_wdata = '0;
    endtask

    // inputs are set after a falling edge by the caller; this holds them one cycle
    task automatic fin();
        @(negedge clk);
        idle();
    endtask

    task automatic clr_all();
        @(negedge clk); clr_we = 1; clr_wdata = 16'hFFFF; fin();
    endtask

    task automatic t_reset();
        chk("R1 flags", rd_flags, 16'h0000);
        chk("R1 ien", rd_ien, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_compare();
        clr_all();
        @(negedge clk); ch_is_out = 4'b1011; ev_cmp_match = 4'b1111; fin();
        chk("R2 compare gated by output mode", rd_flags, 16'h0160);
    endtask

    task automatic t_arr_trig();
        clr_all();
        @(negedge clk); ev_arr_match = 1; ev_trig_edge = 1; tmr_running = 1; fin();
        chk("R3/R4 reload set, trigger ignored while running", rd_flags, 16'h0001);
        @(negedge clk); ev_trig_edge = 1; fin();
        chk("R4 trigger flagged when stopped", rd_flags, 16'h0003);
    endtask

    task automatic t_encoder();
        clr_all();
        @(negedge clk); ev_dir_up = 1; ev_dir_down = 1; fin();
        chk("R5 ignored outside encoder mode", rd_flags, 16'h0000);
        @(negedge clk); enc_mode = 1; ev_dir_up = 1; fin();
        chk("R5 down-to-up", rd_flags, 16'h0008);
        @(negedge clk); enc_mode = 1; ev_dir_down = 1; fin();
        chk("R5 up-to-down", rd_flags, 16'h0018);
    endtask

    task automatic t_update();
        clr_all();
        @(negedge clk); ev_update = 1; fin();
        chk("R6 update set", rd_flags, 16'h0004);
        @(negedge clk); arr_write = 1; fin();
        chk("R6 reload write clears update", rd_flags, 16'h0000);
        @(negedge clk); arr_write = 1; ev_update = 1; fin();
        chk("R9 update wins over reload write", rd_flags, 16'h0004);
    endtask

    task automatic t_wdone();
        clr_all();
        @(negedge clk); wdone_cmp = 4'b1111; fin();
        chk("R7 compare write-complete", rd_flags, 16'h1E00);
        @(negedge clk); wdone_arr = 1; wdone_rep = 1; wdone_ien = 1; fin();
        chk("R7 other write-complete", rd_flags, 16'hFE00);
    endtask

    task automatic t_clear();
        clr_all();
        @(negedge clk); ev_arr_match = 1; ev_trig_edge = 1; ev_update = 1; fin();
        chk("R8 setup", rd_flags, 16'h0007);
        @(negedge clk); clr_we = 1; clr_wdata = 16'h0002; fin();
        chk("R8 one bit cleared", rd_flags, 16'h0005);
        @(negedge clk); clr_we = 1; clr_wdata = 16'h0000; fin();
        chk("R8 zero write no effect", rd_flags, 16'h0005);
        repeat (3) @(negedge clk);
        chk("R12 flags hold", rd_flags, 16'h0005);
    endtask

    task automatic t_collide();
        @(negedge clk); clr_we = 1; clr_wdata = 16'h0001; ev_arr_match = 1; fin();
        chk("R9 set wins over clear", rd_flags, 16'h0005);
    endtask

    task automatic t_irq();
        clr_all();
        @(negedge clk); ien_we = 1; ien_wdata = 16'h0004; fin();
        chk("R11 enable readback", rd_ien, 16'h0004);
        chk("R11 irq idle", {15'd0, irq}, 16'h0000);
        @(negedge clk); ev_arr_match = 1; fin();
        chk("R11 masked flag no irq", {15'd0, irq}, 16'h0000);
        @(negedge clk); ev_update = 1; fin();
        repeat (3) @(negedge clk);
        chk("R11 irq level held", {15'd0, irq}, 16'h0001);
        @(negedge clk); clr_we = 1; clr_wdata = 16'h0004; fin();
        chk("R11 irq drops on clear", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_narrow();
        clr_all();
        @(negedge clk); ch_is_out = 4'b1111; ev_cmp_match = 4'b1111; wdone_cmp = 4'b1111;
        ien_we = 1; ien_wdata = 16'hFFFF; fin();
        chk("R10 full build", rd_flags, 16'h1FE0);
        chk("R10 two channels flags", rd_flags2, 16'h0660);
        chk("R10 two channels enables", rd_ien2, 16'hE67F);
    endtask

    initial begin
        #50000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_compare();
        t_arr_trig();
        t_encoder();
        t_update();
        t_wdone();
        t_clear();
        t_collide();
        t_irq();
        t_narrow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule